// File: doc/BRIEF.md
# Cross-Trial Sample Accumulator

The block folds a fixed number of equal-length trials into one summed trial. Each trial is a run of 8-bit samples arriving one after another on a valid/ready input, with a marker on the sample that closes the trial. The value at position k of every trial is added into a running sum kept for position k only. The sums live in an internal store that is one entry deep per position.

Once the last trial of a batch has been taken in, the input is held off. The stored sums are then sent out on a valid/ready output in position order, with a marker on the final position. When that final sum has been accepted, the input opens again and a new batch begins. The first trial of each batch overwrites the store rather than adding to it, so no clearing pass is needed between batches.

A trial boundary is decided by counting positions, not by the marker. If the marker arrives on the wrong position, or is missing from the final one, a sticky error output is raised. The trial length and the trial count are parameters.

Top module: `trial_accumulator`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and len_error is 0.
- R2: Each output sum at position k equals the sum of the samples at position k of the N trials of that batch.
- R3: Sums are 8 + ceil(log2(N)) bits wide, so N samples of 255 each give exactly 255*N with no wrap.
- R4: The sums leave in position order 0 to TRIAL_LEN-1, and out_last is 1 only on position TRIAL_LEN-1.
- R5: out_valid stays 0 until all N*TRIAL_LEN samples of a batch have been accepted.
- R6: in_ready is 0 from the start of the output phase until the last sum is accepted, and a sample offered in that time is not consumed until in_ready returns.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_valid hold their values.
- R8: The first trial of every batch replaces the stored sums, so no value from an earlier batch appears in a later one.
- R9: len_error goes to 1 when in_end is 1 on a position other than TRIAL_LEN-1, or 0 on position TRIAL_LEN-1. It stays at 1 until reset, and trial boundaries still follow the position count.
- R10: The synchronous active-low reset clears the position and trial counts and the error flag, and drops a partly gathered batch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 8 | Input sample, unsigned |
| in_end | input | 1 | Marks the closing sample of a trial |
| out_valid | output | 1 | Summed sample present |
| out_ready | input | 1 | Downstream takes the summed sample |
| out_data | output | 8+clog2(NUM_TRIALS) | Summed sample, unsigned |
| out_last | output | 1 | Marks position TRIAL_LEN-1 of the summed trial |
| len_error | output | 1 | Sticky trial-length mismatch flag |

## Verification
The hardest case to reach from the ports is the overlap between a stalled output phase and an upstream that already holds the first sample of the next batch. A sample taken in too early would corrupt both batches. The driver therefore presents the next batch's first sample as soon as the previous one is sent, and the monitor withholds out_ready on most cycles. A second hard case is a trial whose end marker is misplaced while the batch still completes on the position count. Batches are run with the marker early or missing in their first trial, and their sums are still checked in full.

// File: rtl/trial_acc_pkg.sv
// Package: shared types and width helpers for the cross-trial accumulator.
// Assumes: counts passed to helpers are at least 1.
package trial_acc_pkg;

    // Operating phase: gathering trials or sending the summed trial.
    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_DRAIN  = 1'b1
    } acc_phase_e;

    // Index width for a count, never below one bit.
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/acc_sum_store.sv
// Module: acc_sum_store
// Holds one running sum per trial position. Writes are synchronous and reads
// are combinational at the same address, so a read-modify-write fits in one cycle.
// Assumes: addr is below DEPTH whenever wr_en is high.
module acc_sum_store #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 10,
    localparam int AW   = trial_acc_pkg::idx_width(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data
);

    logic [DEPTH-1:0][WIDTH-1:0] cell_bus;

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        logic [WIDTH-1:0] cell_q;
        // Update this entry when its address is written.
        always_ff @(posedge clk) begin
            if (wr_en && (addr == AW'(gi))) begin
                cell_q <= wr_data;
            end
        end
        assign cell_bus[gi] = cell_q;
    end

    // Select the addressed entry.
    assign rd_data = cell_bus[addr];

endmodule

// File: rtl/acc_adder.sv
// Module: acc_adder
// Forms the new running sum: the bare sample on a batch's first trial,
// otherwise the stored sum plus the sample.
// Assumes: WIDTH is wide enough that N samples never wrap.
module acc_adder #(
    parameter int SAMPLE_W = 8,
    parameter int WIDTH    = 10
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [WIDTH-1:0]    old_sum,
    input  logic                first,
    output logic [WIDTH-1:0]    new_sum
);

    // Overwrite on the first trial, accumulate on the rest.
    always_comb begin
        if (first) begin
            new_sum = WIDTH'(sample);
        end else begin
            new_sum = old_sum + WIDTH'(sample);
        end
    end

endmodule

// File: rtl/acc_sequencer.sv
// Module: acc_sequencer
// Tracks the position within a trial, the trial within a batch and the phase.
// It gates the input and output handshakes and flags end-marker mismatches.
// Assumes: trial boundaries follow the position count; the marker is only checked.
module acc_sequencer #(
    parameter int TRIAL_LEN  = 16,
    parameter int NUM_TRIALS = 4,
    localparam int IDX_W     = trial_acc_pkg::idx_width(TRIAL_LEN),
    localparam int TRL_W     = trial_acc_pkg::idx_width(NUM_TRIALS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_end,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             out_last,
    output logic             wr_en,
    output logic             first_trial,
    output logic [IDX_W-1:0] pos,
    output logic             len_error
);
    import trial_acc_pkg::*;

    localparam logic [IDX_W-1:0] LAST_POS   = IDX_W'(TRIAL_LEN - 1);
    localparam logic [TRL_W-1:0] LAST_TRIAL = TRL_W'(NUM_TRIALS - 1);

    acc_phase_e       phase_q;
    logic [IDX_W-1:0] pos_q;
    logic [TRL_W-1:0] trial_q;
    logic             err_q;
    logic             at_end;
    logic             accept;
    logic             take;

    assign at_end      = (pos_q == LAST_POS);
    assign in_ready    = (phase_q == PH_GATHER);
    assign out_valid   = (phase_q == PH_DRAIN);
    assign out_last    = out_valid && at_end;
    assign accept      = in_valid && in_ready;
    assign take        = out_valid && out_ready;
    assign wr_en       = accept;
    assign first_trial = (trial_q == '0);
    assign pos         = pos_q;
    assign len_error   = err_q;

    // Advance position, trial count and phase on each handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_GATHER;
            pos_q   <= '0;
            trial_q <= '0;
        end else if (phase_q == PH_GATHER) begin
            if (accept) begin
                if (at_end) begin
                    pos_q <= '0;
                    if (trial_q == LAST_TRIAL) begin
                        trial_q <= '0;
                        phase_q <= PH_DRAIN;
                    end else begin
                        trial_q <= trial_q + 1'b1;
                    end
                end else begin
                    pos_q <= pos_q + 1'b1;
                end
            end
        end else if (take) begin
            if (at_end) begin
                pos_q   <= '0;
                phase_q <= PH_GATHER;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end

    // Latch a mismatch between the end marker and the position count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (accept && (in_end != at_end)) begin
            err_q <= 1'b1;
        end
    end

    // R5: the output phase begins only on the cycle after an accepted sample.
    assert_drain_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready));

    // R4: a non-final sum taken is followed by another sum.
    assert_drain_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> out_valid);

    // R6: the input opens again right after the final sum is taken.
    assert_resume_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> (!out_valid && in_ready));

    // R9: the error flag is sticky.
    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        len_error |=> len_error);

endmodule

// File: rtl/trial_accumulator.sv
// Module: trial_accumulator (top)
// Sums NUM_TRIALS trials of TRIAL_LEN unsigned samples position by position,
// then sends the summed trial in order while the input is held off.
// Assumes: unsigned samples; the downstream may stall at any cycle.
module trial_accumulator #(
    parameter int SAMPLE_W   = 8,
    parameter int TRIAL_LEN  = 16,
    parameter int NUM_TRIALS = 4,
    localparam int SUM_W     = SAMPLE_W + $clog2(NUM_TRIALS),
    localparam int IDX_W     = trial_acc_pkg::idx_width(TRIAL_LEN)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                in_end,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [SUM_W-1:0]    out_data,
    output logic                out_last,
    output logic                len_error
);

    logic             wr_en;
    logic             first_trial;
    logic [IDX_W-1:0] pos;
    logic [SUM_W-1:0] rd_sum;
    logic [SUM_W-1:0] wr_sum;

    acc_sequencer #(
        .TRIAL_LEN (TRIAL_LEN),
        .NUM_TRIALS(NUM_TRIALS)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_end     (in_end),
        .out_ready  (out_ready),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_last   (out_last),
        .wr_en      (wr_en),
        .first_trial(first_trial),
        .pos        (pos),
        .len_error  (len_error)
    );

    acc_adder #(
        .SAMPLE_W(SAMPLE_W),
        .WIDTH   (SUM_W)
    ) i_add (
        .sample (in_data),
        .old_sum(rd_sum),
        .first  (first_trial),
        .new_sum(wr_sum)
    );

    acc_sum_store #(
        .DEPTH(TRIAL_LEN),
        .WIDTH(SUM_W)
    ) i_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .addr   (pos),
        .wr_data(wr_sum),
        .rd_data(rd_sum)
    );

    assign out_data = rd_sum;

    // R3: an accumulating write never wraps below the stored sum.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !first_trial) |-> (wr_sum >= rd_sum));

    // R7: a stalled output holds its value.
    assert_hold_when_stalled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/test_trial_accumulator.sv
// Scoreboard bench: the driver pushes expected sums, the monitor pops and compares.
module test_trial_accumulator;
    localparam int CLK_PERIOD = 10;
    localparam int L    = 8;
    localparam int N    = 3;
    localparam int SW   = 8;
    localparam int SUMW = SW + $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SW-1:0] in_data = '0;
    logic in_end = 1'b0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [SUMW-1:0] out_data;
    logic out_last;
    logic len_error;

    int checks = 0;
    int failures = 0;
    bit stall_on = 1'b0;
    bit done = 1'b0;
    int cyc = 0;
    int exp_q[$];
    bit hold_prev = 1'b0;
    logic [SUMW-1:0] prev_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trial_accumulator #(.SAMPLE_W(SW), .TRIAL_LEN(L), .NUM_TRIALS(N)) i_trial_accumulator (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_end(in_end), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .len_error(len_error));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Offer one sample from a falling edge; returns at the falling edge after it is taken.
    task automatic send_sample(input logic [SW-1:0] d, input bit e);
        in_valid = 1'b1;
        in_data = d;
        in_end = e;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [SW-1:0] pick(input int seed, input int mode, input int t, input int k);
        if (mode == 1) return 8'hFF;
        if (mode == 2) return 8'h00;
        return SW'((seed * 37 + t * 11 + k * 29 + t * k * 5) & 255);
    endfunction

    // bad: 0 clean, 1 early marker in trial 0, 2 missing marker in trial 0.
    task automatic run_batch(input int seed, input int mode, input int bad);
        int sums[L];
        for (int k = 0; k < L; k++) begin
            sums[k] = 0;
            for (int t = 0; t < N; t++) sums[k] += int'(pick(seed, mode, t, k));
            exp_q.push_back(sums[k] + ((k == L-1) ? (1 << 16) : 0));
        end
        for (int t = 0; t < N; t++) begin
            for (int k = 0; k < L; k++) begin
                bit e;
                e = (k == L-1);
                if (t == 0 && bad == 1 && k == 2) e = 1'b1;
                if (t == 0 && bad == 2 && k == L-1) e = 1'b0;
                send_sample(pick(seed, mode, t, k), e);
            end
            // R5: no output before the batch is complete.
            if (t == N-2) check(out_valid == 1'b0, "R5 out_valid before last trial", int'(out_valid), 0);
        end
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: drive out_ready, then compare a transfer due at the next rising edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            hold_prev = 1'b0;
            out_ready = 1'b1;
        end else begin
            out_ready = stall_on ? ((cyc % 3) == 0) : 1'b1;
            if (hold_prev) begin
                check(out_valid && (out_data == prev_data), "R7 held value under stall",
                      int'(out_data), int'(prev_data));
            end
            if (out_valid) begin
                // R6: input closed during output.
                check(in_ready == 1'b0, "R6 in_ready during output", int'(in_ready), 0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected output", int'(out_data), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(out_data) == (e & 16'hFFFF), "R2 sum value", int'(out_data), e & 16'hFFFF);
                    check(out_last == ((e >> 16) != 0), "R4 out_last position", int'(out_last), e >> 16);
                end
            end
            hold_prev = out_valid && !out_ready;
            prev_data = out_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state.
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(len_error == 1'b0, "R1 len_error after reset", int'(len_error), 0);

        // R2, R4: plain batch.
        run_batch(1, 0, 0);
        // R6, R7, R8: back-to-back batches under output stall.
        stall_on = 1'b1;
        run_batch(2, 0, 0);
        // R3: full-scale samples must give 255*N.
        run_batch(3, 1, 0);
        // R8: zero batch exposes any residue.
        run_batch(4, 2, 0);
        wait_drain();
        stall_on = 1'b0;
        check(len_error == 1'b0, "R9 no error on clean trials", int'(len_error), 0);

        // R10: partial batch dropped by reset.
        for (int k = 0; k < L + 3; k++) send_sample(8'h55, (k == L-1));
        do_reset();
        @(negedge clk);
        check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        run_batch(5, 0, 0);
        wait_drain();

        // R9: early marker flags error, count still governs.
        run_batch(6, 0, 1);
        wait_drain();
        check(len_error == 1'b1, "R9 early marker", int'(len_error), 1);
        do_reset();
        @(negedge clk);
        check(len_error == 1'b0, "R10 error cleared by reset", int'(len_error), 0);

        // R9: missing marker flags error.
        stall_on = 1'b1;
        run_batch(7, 0, 2);
        wait_drain();
        check(len_error == 1'b1, "R9 missing marker", int'(len_error), 1);

        check(exp_q.size() == 0, "R2 all sums delivered", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule